// File: doc/BRIEF.md
# PPS and Target-Time Generator

This block turns a free-running precision time value (a seconds count plus a binary sub-second fraction) into a pulse-per-second signal and into target-time events. A small control register selects how the PPS line behaves. At the slowest setting the line gives a single one-cycle pulse each time the seconds value advances. The faster settings give power-of-two square waves, derived straight from the sub-second fraction, with a rising edge on every second boundary. The time value itself comes from outside the block and is sampled on every clock.

A target-time comparator watches the same time value. Writing the target sub-second register arms it. The first clock edge at which the time is at or beyond the programmed seconds:fraction point fires the comparator once and disarms it. The two-bit target mode in the control register decides what a firing does:

- raise only a one-cycle interrupt;
- raise the interrupt and also force a pulse onto the PPS line;
- raise no interrupt and instead start or stop the PPS line.

In stop mode the line is held low until a firing starts it. The next firing stops it again. The 4-bit control field is read as a frequency selector only while the interpretation bit is clear. While that bit is set, the field is a command, and commands do not disturb the running frequency.

Top module: `pps_tgt_gen`

## Requirements
- R1: After reset, ppsOut and irqOut are 0, the frequency selector is 0, the target mode is 0, and the comparator is disarmed.
- R2: A write to address 0 loads the target mode from data bits 6:5. If data bit 4 is 0, data bits 3:0 become the frequency selector. If data bit 4 is 1, the write is a command (including command 0) and the frequency selector keeps its value.
- R3: With frequency selector 0, ppsOut is high for exactly one cycle, in the cycle after a clock edge at which secIn differs from its value at the previous edge. This never happens at the first edge after reset.
- R4: With frequency selector N (1 to 15), ppsOut in the cycle after an edge equals the inverse of bit SUBSEC_W-1-N of subIn sampled at that edge. This gives a 2^N Hz square wave that rises at each second boundary.
- R5: Address 1 loads the target seconds and address 2 loads the target fraction; a write to address 2 arms the comparator. While armed, the first edge at which {secIn,subIn} is greater than or equal to {target seconds, target fraction} fires the comparator once and disarms it. A sample that jumps past the target also fires it.
- R6: In target modes 0, 1 and 2, irqOut is high for exactly the one cycle after the firing edge. In mode 3, irqOut stays low.
- R7: In target mode 2, ppsOut is also high in the cycle after the firing edge. In modes 0 and 1, a firing does not affect ppsOut.
- R8: A control write with target mode other than 3 clears the started state. In mode 3, ppsOut is held low while not started. Each firing toggles the started state, so the first firing after arming starts the PPS output and the next one stops it. Outside mode 3 the PPS output always runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PTP-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 target seconds, 2 target fraction |
| regWrData | input | DATA_W | Write data |
| secIn | input | SEC_W | Seconds part of the current time |
| subIn | input | SUBSEC_W | Binary sub-second fraction of the current time |
| ppsOut | output | 1 | Pulse-per-second / square-wave output |
| irqOut | output | 1 | One-cycle target-time interrupt pulse |

## Verification
The hardest case to reach is the stop/start sequence in target mode 3. Observing it needs a mode change that clears the started state, one armed firing that starts the line, and a second armed firing that stops it, with square-wave activity checked in between. The stimulus gets there by driving the time input directly, jumping seconds and fractions to any value instead of counting up a real second. It re-arms the target between firings. The bench keeps a step-by-step arithmetic model of the expected PPS and interrupt values, so every cycle of each sweep over all sixteen frequency settings and all four target modes is compared.

// File: rtl/ppsgen_pkg.sv
package ppsgen_pkg;

  // Control register field positions (decoded by the control module).
  localparam int MODE_LSB = 5;
  localparam int CMD_BIT  = 4;
  localparam int FIELD_W  = 4;
  localparam int TAP_N    = 1 << FIELD_W;

  localparam logic [1:0] ADDR_CTRL    = 2'd0;
  localparam logic [1:0] ADDR_TGT_SEC = 2'd1;
  localparam logic [1:0] ADDR_TGT_SUB = 2'd2;

  typedef enum logic [1:0] {
    TGT_IRQ       = 2'd0,
    TGT_RSVD      = 2'd1,
    TGT_IRQ_PPS   = 2'd2,
    TGT_STARTSTOP = 2'd3
  } tgtMode_e;

  // Strobes and settings from control to datapath.
  typedef struct packed {
    logic [FIELD_W-1:0] freqSel;
    logic               drivePulse;
    logic               runEn;
  } ppsStrobe_t;

endpackage

// File: rtl/ppsgen_ctrl.sv
module ppsgen_ctrl
  import ppsgen_pkg::*;
#(
  parameter int SEC_W    = 32,
  parameter int SUBSEC_W = 31,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [SEC_W-1:0]    secIn,
  input  logic [SUBSEC_W-1:0] subIn,
  output ppsStrobe_t          strb,
  output logic                irqOut
);

  tgtMode_e            modeQ;
  logic [FIELD_W-1:0]  freqQ;
  logic [SEC_W-1:0]    tgtSecQ;
  logic [SUBSEC_W-1:0] tgtSubQ;
  logic                armedQ;
  logic                startedQ;

  logic ctrlWr, secWr, subWr;
  logic reached, fire;
  tgtMode_e wrMode;

  assign ctrlWr  = regWrEn && (regAddr == ADDR_CTRL);
  assign secWr   = regWrEn && (regAddr == ADDR_TGT_SEC);
  assign subWr   = regWrEn && (regAddr == ADDR_TGT_SUB);
  assign wrMode  = tgtMode_e'(regWrData[MODE_LSB +: 2]);

  // Lexicographic compare: seconds first, then fraction.
  assign reached = {secIn, subIn} >= {tgtSecQ, tgtSubQ};
  assign fire    = armedQ && reached;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= TGT_IRQ;
      freqQ    <= '0;
      tgtSecQ  <= '0;
      tgtSubQ  <= '0;
      armedQ   <= 1'b0;
      startedQ <= 1'b0;
      irqOut   <= 1'b0;
    end else begin
      if (ctrlWr) begin
        modeQ <= wrMode;
        if (!regWrData[CMD_BIT]) freqQ <= regWrData[FIELD_W-1:0];
      end
      if (secWr) tgtSecQ <= regWrData[SEC_W-1:0];
      if (subWr) tgtSubQ <= regWrData[SUBSEC_W-1:0];

      if (subWr)     armedQ <= 1'b1;
      else if (fire) armedQ <= 1'b0;

      if (ctrlWr && (wrMode != TGT_STARTSTOP))       startedQ <= 1'b0;
      else if (fire && (modeQ == TGT_STARTSTOP))     startedQ <= !startedQ;

      irqOut <= fire && (modeQ != TGT_STARTSTOP);
    end
  end

  always_comb begin
    strb.freqSel    = freqQ;
    strb.drivePulse = fire && (modeQ == TGT_IRQ_PPS);
    strb.runEn      = (modeQ != TGT_STARTSTOP) || startedQ;
  end

  a_r2_cmd_keeps_freq: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[CMD_BIT]) |=> $stable(freqQ));

  a_r5_single_fire: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> (!armedQ || $past(subWr)));

  a_r6_no_irq_mode3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ($past(modeQ) != TGT_STARTSTOP));

endmodule

// File: rtl/ppsgen_dp.sv
module ppsgen_dp
  import ppsgen_pkg::*;
#(
  parameter int SEC_W    = 32,
  parameter int SUBSEC_W = 31
) (
  input  logic                clk,
  input  logic                rstN,
  input  ppsStrobe_t          strb,
  input  logic [SEC_W-1:0]    secIn,
  input  logic [SUBSEC_W-1:0] subIn,
  output logic                ppsOut
);

  logic [SEC_W-1:0] prevSecQ;
  logic             primedQ;
  logic             secEdge;
  logic [TAP_N-1:0] taps;
  logic             base;

  assign secEdge = primedQ && (secIn != prevSecQ);

  // Tap 0: one-cycle seconds pulse; tap N: 2^N Hz square wave
  // high in the first half of each period.
  assign taps[0] = secEdge;
  for (genvar n = 1; n < TAP_N; n++) begin : g_tap
    assign taps[n] = ~subIn[SUBSEC_W-1-n];
  end

  assign base = taps[strb.freqSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSecQ <= '0;
      primedQ  <= 1'b0;
      ppsOut   <= 1'b0;
    end else begin
      prevSecQ <= secIn;
      primedQ  <= 1'b1;
      ppsOut   <= strb.runEn && (base || strb.drivePulse);
    end
  end

  a_r8_stopped_low: assert property (@(posedge clk) disable iff (!rstN)
    !strb.runEn |=> !ppsOut);

  a_r3_sec_pulse_on_change: assert property (@(posedge clk) disable iff (!rstN)
    (ppsOut && ($past(strb.freqSel) == '0) && !$past(strb.drivePulse))
      |-> ($past(secIn) != $past(secIn, 2)));

endmodule

// File: rtl/pps_tgt_gen.sv
module pps_tgt_gen
  import ppsgen_pkg::*;
#(
  parameter int SEC_W    = 32,
  parameter int SUBSEC_W = 31,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [SEC_W-1:0]    secIn,
  input  logic [SUBSEC_W-1:0] subIn,
  output logic                ppsOut,
  output logic                irqOut
);

  ppsStrobe_t strb;

  ppsgen_ctrl #(
    .SEC_W(SEC_W), .SUBSEC_W(SUBSEC_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .secIn(secIn), .subIn(subIn),
    .strb(strb), .irqOut(irqOut)
  );

  ppsgen_dp #(
    .SEC_W(SEC_W), .SUBSEC_W(SUBSEC_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .secIn(secIn), .subIn(subIn),
    .ppsOut(ppsOut)
  );

endmodule

// File: tb/pps_tgt_gen_tb_top.sv
`timescale 1ns/1ps
module pps_tgt_gen_tb_top;

  localparam int SEC_W = 32;
  localparam int SUB_W = 31;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [1:0]       regAddr = '0;
  logic [31:0]      regWrData = '0;
  logic [SEC_W-1:0] secIn = '0;
  logic [SUB_W-1:0] subIn = '0;
  logic             ppsOut, irqOut;

  always #2 clk = ~clk;

  pps_tgt_gen dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .secIn(secIn), .subIn(subIn),
    .ppsOut(ppsOut), .irqOut(irqOut)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string curReq = "R1";

  // Arithmetic model of the requirements
  logic [1:0]       mMode;
  logic [3:0]       mFreq;
  logic [SEC_W-1:0] mTSec, mPrevSec;
  logic [SUB_W-1:0] mTSub;
  bit               mArmed, mStarted, mPrimed;

  task automatic check(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", curReq, what, act, exp);
    end
  endtask

  task automatic tick(input bit doWr, input logic [1:0] a, input logic [31:0] d,
                      input logic [SEC_W-1:0] s, input logic [SUB_W-1:0] f);
    logic ge, fire, base, run, expPps, expIrq;
    @(negedge clk);
    secIn = s; subIn = f;
    regWrEn = doWr; regAddr = a; regWrData = d;
    ge     = {s, f} >= {mTSec, mTSub};
    fire   = mArmed && ge;
    base   = (mFreq == 0) ? (mPrimed && (s != mPrevSec)) : ~f[SUB_W-1-int'(mFreq)];
    run    = (mMode != 2'd3) || mStarted;
    expPps = run && (base || (fire && mMode == 2'd2));
    expIrq = fire && (mMode != 2'd3);
    mPrimed = 1; mPrevSec = s;
    if (fire) mArmed = 0;
    if (fire && mMode == 2'd3) mStarted = !mStarted;
    if (doWr) begin
      case (a)
        2'd0: begin
          mMode = d[6:5];
          if (!d[4]) mFreq = d[3:0];
          if (d[6:5] != 2'd3) mStarted = 0;
        end
        2'd1: mTSec = d;
        2'd2: begin mTSub = d[SUB_W-1:0]; mArmed = 1; end
        default: ;
      endcase
    end
    @(posedge clk); #1;
    regWrEn = 1'b0;
    check("ppsOut", ppsOut, expPps);
    check("irqOut", irqOut, expIrq);
  endtask

  task automatic step(input logic [SEC_W-1:0] s, input logic [SUB_W-1:0] f);
    tick(0, 2'd0, 32'd0, s, f);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    tick(1, a, d, secIn, subIn);
  endtask

  // Sweep the sub-second fraction over both halves of the tap for freq n.
  task automatic sweepSub(input logic [SEC_W-1:0] s, input int n);
    for (int i = 0; i < 8; i++) step(s, SUB_W'(i) << (28 - n));
    step(s, (SUB_W'(4) << (28 - n)) - 1);
    step(s, SUB_W'(4) << (28 - n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mMode = 0; mFreq = 0; mTSec = 0; mTSub = 0; mPrevSec = 0;
    mArmed = 0; mStarted = 0; mPrimed = 0;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    curReq = "R1";
    check("ppsOut", ppsOut, 1'b0);
    check("irqOut", irqOut, 1'b0);
    @(negedge clk); rstN = 1'b1;
    step(0, 0);
    step(0, 100);

    // R3: one-cycle pulse when seconds change
    curReq = "R3";
    for (int s = 1; s < 10; s++)
      for (int c = 0; c < 4; c++) step(SEC_W'(s), SUB_W'(c * 1000));
    step(5, 0);
    step(5, 7);

    // R4: every square-wave frequency
    curReq = "R4";
    for (int n = 1; n < 16; n++) begin
      wr(2'd0, 32'(n));
      sweepSub(20, n);
    end

    // R2: command writes keep the frequency
    curReq = "R2";
    wr(2'd0, 32'h03);
    sweepSub(21, 3);
    wr(2'd0, 32'h19);
    sweepSub(21, 3);
    wr(2'd0, 32'h10);
    sweepSub(22, 3);
    wr(2'd0, 32'h00);
    step(23, 0);
    step(23, 5);

    // R5 / R6: mode 0, exact hit, fires once
    curReq = "R5";
    wr(2'd1, 32'd50);
    wr(2'd2, 32'd1000);
    step(49, 0);
    step(50, 0);
    step(50, 999);
    curReq = "R6";
    step(50, 1000);
    step(50, 5000);
    step(51, 0);
    // R5: mode 1 with seconds ahead but fraction behind
    curReq = "R5";
    wr(2'd0, 32'h20);
    wr(2'd1, 32'd60);
    wr(2'd2, 32'd500);
    step(60, 100);
    step(61, 0);
    step(61, 1);

    // R7: mode 2 forces a PPS pulse
    curReq = "R7";
    wr(2'd0, 32'h40);
    wr(2'd1, 32'd70);
    wr(2'd2, 32'd100);
    step(70, 50);
    step(70, 51);
    step(70, 100);
    step(70, 200);

    // R8: mode 3 start then stop, freq 2
    curReq = "R8";
    wr(2'd0, 32'h62);
    sweepSub(80, 2);
    wr(2'd1, 32'd81);
    wr(2'd2, 32'd0);
    step(80, 5);
    step(81, 0);
    sweepSub(82, 2);
    wr(2'd1, 32'd90);
    wr(2'd2, 32'd0);
    sweepSub(85, 2);
    step(90, 0);
    sweepSub(91, 2);
    // leaving mode 3 runs the output again
    wr(2'd0, 32'h02);
    sweepSub(92, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule